// File: doc/BRIEF.md
# Privileged Status and Control Register Block

This block holds the processor's 16-bit status word, the two 3-bit alternate address-space codes (one for source operands, one for destination operands) and the banked pair of stack pointers that software reaches as address register 7. The privilege level is the supervisor bit inside the status word. Every access through the register port is checked against that level. The access must also have a size the target accepts. Bits that carry no meaning are forced to zero both on reads and on writes. The stack-pointer alias follows the supervisor bit, so leaving supervisor mode switches the visible pointer on the same edge that clears the bit.

The register port is a plain single-cycle port and has no back-pressure: an access is taken on any clock edge with `acc_en` high. A read returns its data combinationally in the same cycle. A write takes effect at the edge. A rejected access leaves every register unchanged and raises `priv_viol` or `size_err` for the one cycle after the edge. A separate narrow port lets the ALU load new condition flags directly. The trace, supervisor, interrupt-mask, condition-flag and address-space fields, together with the active stack pointer, are driven straight out as plain signals for the rest of the core.

Selector codes on `acc_sel`: 0 full status word, 1 condition byte, 2 source space code, 3 destination space code, 4 stack-pointer alias, 5 user stack pointer explicitly, 6 and 7 unused. Size codes on `acc_size`: 0 byte, 1 word, 2 long, 3 invalid.

Top module: `priv_ctrl_regs`

## Requirements
- R1: After reset the status word reads 0x2700 (supervisor set, interrupt mask 7, trace and condition flags clear), both stack pointers are zero and both space codes are zero.
- R2: The status word defines only bit 15:14 (trace enables), bit 13 (supervisor), bits 10:8 (interrupt mask) and bits 4:0 (flags X N Z V C, MSB first). All other bits read as zero, writes to them are dropped, and upper data bits 31:16 read as zero.
- R3: The condition byte (selector 1) is word-sized and accepted at both privilege levels. It reads bits 4:0 of the status word with all other data bits zero. A write loads bits 4:0 only and ignores the rest of the data.
- R4: In user mode (bit 13 clear), any access to selectors 0, 2, 3 or 5 is rejected. The read data is zero, no state changes, and `priv_viol` is high for the following cycle. Nothing in the block can set the supervisor bit from user mode.
- R5: The space-code registers (selectors 2 and 3) need long size. They store data bits 2:0 only and read back with bits 31:3 zero.
- R6: The alias (selector 4 and output `a7_ptr`) addresses the supervisor pointer while bit 13 is set and the user pointer while it is clear. A supervisor write that clears bit 13 shows `super_mode` low and `a7_ptr` equal to the user pointer from the next cycle on.
- R7: A long write to selector 4 or 5 stores all 32 bits. A word write stores data bits 15:0 sign-extended to 32 bits. A word read returns the low 16 bits zero-extended.
- R8: An access that passes the privilege check but has a size the target does not accept is rejected. This covers selectors 0 and 1 unless size is word, selectors 2 and 3 unless long, and selectors 4 and 5 when byte or invalid. The read data is zero, no state changes, and `size_err` is high for the following cycle. `priv_viol` and `size_err` are never high together; the privilege check takes precedence.
- R9: `ccr_upd_en` loads `ccr_upd_val` into flag bits 4:0 at the edge. If a legal port write to selector 0 or 1 occurs in the same cycle, the port write wins.
- R10: `trace_en`, `super_mode`, `int_mask` and `ccr_flags` always equal the corresponding status-word fields. `sfc_code` and `dfc_code` equal the space-code registers.
- R11: Selectors 6 and 7 read as zero at any size and level, ignore writes, and raise neither error output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_en | input | 1 | Access strobe for the register port |
| acc_wr | input | 1 | 1 = write, 0 = read |
| acc_sel | input | 3 | Target selector (codes in the description) |
| acc_size | input | 2 | Access size: 0 byte, 1 word, 2 long, 3 invalid |
| acc_wdata | input | DATA_W | Write data |
| acc_rdata | output | DATA_W | Read data, valid in the access cycle |
| priv_viol | output | 1 | Privilege fault pulse, cycle after the access |
| size_err | output | 1 | Size fault pulse, cycle after the access |
| ccr_upd_en | input | 1 | Direct flag update strobe from the ALU |
| ccr_upd_val | input | 5 | New flags X N Z V C |
| trace_en | output | 2 | Trace enable bits |
| super_mode | output | 1 | Supervisor bit |
| int_mask | output | 3 | Interrupt priority mask |
| ccr_flags | output | 5 | Condition flags X N Z V C |
| sfc_code | output | FC_W | Source address-space code |
| dfc_code | output | FC_W | Destination address-space code |
| a7_ptr | output | DATA_W | Currently selected stack pointer |

## Verification
The bench builds the block with its defaults: DATA_W = 32, FC_W = 3 and a reset status word of 0x2700. It starts in supervisor mode. At this size every selector, every size code and both directions can be crossed with a handful of data patterns (all ones, all zeros, alternating, sign-bit-only) at both privilege levels. Each legality decision and each masking rule is therefore reached by every combination rather than by samples. The user-mode pass runs after supervisor writes have made the two stack pointers differ. This lets the alias switch and the sign extension be told apart by value.

// File: rtl/priv_ctrl_pkg.sv
package priv_ctrl_pkg;

  typedef enum logic [2:0] {
    SEL_SR   = 3'd0,
    SEL_CCR  = 3'd1,
    SEL_SFC  = 3'd2,
    SEL_DFC  = 3'd3,
    SEL_A7   = 3'd4,
    SEL_USP  = 3'd5,
    SEL_RSV6 = 3'd6,
    SEL_RSV7 = 3'd7
  } reg_sel_e;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_WORD = 2'd1,
    SZ_LONG = 2'd2,
    SZ_BAD  = 2'd3
  } acc_size_e;

  localparam int SR_W        = 16;
  localparam int FLAG_W      = 5;
  localparam int MASK_W      = 3;
  localparam int TRACE_W     = 2;
  localparam int S_BIT       = 13;
  localparam int MASK_LSB    = 8;
  localparam int TRACE_LSB   = 14;
  localparam logic [SR_W-1:0] SR_DEFINED = 16'hE71F;

endpackage

// File: rtl/priv_access_check.sv
module priv_access_check
  import priv_ctrl_pkg::*;
(
  input  logic       acc_en,
  input  logic       acc_wr,
  input  logic [2:0] acc_sel,
  input  logic [1:0] acc_size,
  input  logic       super_mode,
  output logic       priv_fault,
  output logic       size_fault,
  output logic       rd_ok,
  output logic       wr_sr,
  output logic       wr_ccr,
  output logic [1:0] wr_fc,
  output logic       wr_a7,
  output logic       wr_usp
);

  logic needs_super;
  logic size_good;
  logic pass;

  always_comb begin
    needs_super = 1'b0;
    size_good   = 1'b1;
    case (acc_sel)
      SEL_SR: begin
        needs_super = 1'b1;
        size_good   = (acc_size == SZ_WORD);
      end
      SEL_CCR: size_good = (acc_size == SZ_WORD);
      SEL_SFC, SEL_DFC: begin
        needs_super = 1'b1;
        size_good   = (acc_size == SZ_LONG);
      end
      SEL_A7: size_good = (acc_size == SZ_WORD) || (acc_size == SZ_LONG);
      SEL_USP: begin
        needs_super = 1'b1;
        size_good   = (acc_size == SZ_WORD) || (acc_size == SZ_LONG);
      end
      default: begin
        needs_super = 1'b0;
        size_good   = 1'b1;
      end
    endcase
  end

  assign priv_fault = acc_en && needs_super && !super_mode;
  assign size_fault = acc_en && !priv_fault && !size_good;
  assign pass       = acc_en && !priv_fault && size_good;
  assign rd_ok      = pass && !acc_wr;
  assign wr_sr      = pass && acc_wr && (acc_sel == SEL_SR);
  assign wr_ccr     = pass && acc_wr && (acc_sel == SEL_CCR);
  assign wr_fc[0]   = pass && acc_wr && (acc_sel == SEL_SFC);
  assign wr_fc[1]   = pass && acc_wr && (acc_sel == SEL_DFC);
  assign wr_a7      = pass && acc_wr && (acc_sel == SEL_A7);
  assign wr_usp     = pass && acc_wr && (acc_sel == SEL_USP);

endmodule

// File: rtl/priv_status_reg.sv
module priv_status_reg
  import priv_ctrl_pkg::*;
#(
  parameter logic [SR_W-1:0] SR_RESET = 16'h2700
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_sr,
  input  logic              wr_ccr,
  input  logic [SR_W-1:0]   wdata,
  input  logic              upd_en,
  input  logic [FLAG_W-1:0] upd_val,
  output logic [SR_W-1:0]   sr_word
);

  logic [SR_W-1:0] sr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q <= SR_RESET & SR_DEFINED;
    end else if (wr_sr) begin
      sr_q <= wdata & SR_DEFINED;
    end else if (wr_ccr) begin
      sr_q[FLAG_W-1:0] <= wdata[FLAG_W-1:0];
    end else if (upd_en) begin
      sr_q[FLAG_W-1:0] <= upd_val;
    end
  end

  assign sr_word = sr_q;

endmodule

// File: rtl/priv_fc_reg.sv
module priv_fc_reg #(
  parameter int FC_W = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr,
  input  logic [FC_W-1:0] wdata,
  output logic [FC_W-1:0] code
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  code <= '0;
    else if (wr) code <= wdata;
  end

endmodule

// File: rtl/priv_stack_bank.sv
module priv_stack_bank
  import priv_ctrl_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter logic [DATA_W-1:0] SP_RESET = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              super_mode,
  input  logic              wr_a7,
  input  logic              wr_usp,
  input  logic [1:0]        size,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] active_sp,
  output logic [DATA_W-1:0] user_sp
);

  localparam int HALF_W = DATA_W / 2;

  logic [DATA_W-1:0] usp_q;
  logic [DATA_W-1:0] ssp_q;
  logic [DATA_W-1:0] wr_val;

  assign wr_val = (size == SZ_WORD)
                ? {{(DATA_W-HALF_W){wdata[HALF_W-1]}}, wdata[HALF_W-1:0]}
                : wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      usp_q <= SP_RESET;
      ssp_q <= SP_RESET;
    end else begin
      if (wr_a7 && super_mode) ssp_q <= wr_val;
      if ((wr_a7 && !super_mode) || wr_usp) usp_q <= wr_val;
    end
  end

  assign active_sp = super_mode ? ssp_q : usp_q;
  assign user_sp   = usp_q;

endmodule

// File: rtl/priv_ctrl_regs.sv
module priv_ctrl_regs
  import priv_ctrl_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int FC_W   = 3,
  parameter logic [SR_W-1:0]   SR_RESET = 16'h2700,
  parameter logic [DATA_W-1:0] SP_RESET = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_en,
  input  logic              acc_wr,
  input  logic [2:0]        acc_sel,
  input  logic [1:0]        acc_size,
  input  logic [DATA_W-1:0] acc_wdata,
  output logic [DATA_W-1:0] acc_rdata,
  output logic              priv_viol,
  output logic              size_err,
  input  logic              ccr_upd_en,
  input  logic [FLAG_W-1:0] ccr_upd_val,
  output logic [TRACE_W-1:0] trace_en,
  output logic              super_mode,
  output logic [MASK_W-1:0] int_mask,
  output logic [FLAG_W-1:0] ccr_flags,
  output logic [FC_W-1:0]   sfc_code,
  output logic [FC_W-1:0]   dfc_code,
  output logic [DATA_W-1:0] a7_ptr
);

  localparam int HALF_W = DATA_W / 2;
  localparam int NUM_FC = 2;

  logic [SR_W-1:0]   sr_word;
  logic              priv_fault, size_fault, rd_ok;
  logic              wr_sr, wr_ccr, wr_a7, wr_usp;
  logic [NUM_FC-1:0] wr_fc;
  logic [FC_W-1:0]   fc_q [NUM_FC];
  logic [DATA_W-1:0] active_sp, user_sp;
  logic [DATA_W-1:0] rd_val;
  logic              priv_viol_q, size_err_q;

  assign super_mode = sr_word[S_BIT];

  priv_access_check u_check (
    .acc_en     (acc_en),
    .acc_wr     (acc_wr),
    .acc_sel    (acc_sel),
    .acc_size   (acc_size),
    .super_mode (super_mode),
    .priv_fault (priv_fault),
    .size_fault (size_fault),
    .rd_ok      (rd_ok),
    .wr_sr      (wr_sr),
    .wr_ccr     (wr_ccr),
    .wr_fc      (wr_fc),
    .wr_a7      (wr_a7),
    .wr_usp     (wr_usp)
  );

  priv_status_reg #(.SR_RESET(SR_RESET)) u_status (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_sr   (wr_sr),
    .wr_ccr  (wr_ccr),
    .wdata   (acc_wdata[SR_W-1:0]),
    .upd_en  (ccr_upd_en),
    .upd_val (ccr_upd_val),
    .sr_word (sr_word)
  );

  for (genvar g = 0; g < NUM_FC; g++) begin : g_fc
    priv_fc_reg #(.FC_W(FC_W)) u_fc (
      .clk   (clk),
      .rst_n (rst_n),
      .wr    (wr_fc[g]),
      .wdata (acc_wdata[FC_W-1:0]),
      .code  (fc_q[g])
    );
  end

  priv_stack_bank #(.DATA_W(DATA_W), .SP_RESET(SP_RESET)) u_stack (
    .clk        (clk),
    .rst_n      (rst_n),
    .super_mode (super_mode),
    .wr_a7      (wr_a7),
    .wr_usp     (wr_usp),
    .size       (acc_size),
    .wdata      (acc_wdata),
    .active_sp  (active_sp),
    .user_sp    (user_sp)
  );

  always_comb begin
    rd_val = '0;
    case (acc_sel)
      SEL_SR:  rd_val[SR_W-1:0]   = sr_word;
      SEL_CCR: rd_val[FLAG_W-1:0] = sr_word[FLAG_W-1:0];
      SEL_SFC: rd_val[FC_W-1:0]   = fc_q[0];
      SEL_DFC: rd_val[FC_W-1:0]   = fc_q[1];
      SEL_A7:  rd_val = (acc_size == SZ_WORD)
                      ? {{(DATA_W-HALF_W){1'b0}}, active_sp[HALF_W-1:0]}
                      : active_sp;
      SEL_USP: rd_val = (acc_size == SZ_WORD)
                      ? {{(DATA_W-HALF_W){1'b0}}, user_sp[HALF_W-1:0]}
                      : user_sp;
      default: rd_val = '0;
    endcase
  end

  assign acc_rdata = rd_ok ? rd_val : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      priv_viol_q <= 1'b0;
      size_err_q  <= 1'b0;
    end else begin
      priv_viol_q <= priv_fault;
      size_err_q  <= size_fault;
    end
  end

  assign priv_viol = priv_viol_q;
  assign size_err  = size_err_q;
  assign trace_en  = sr_word[TRACE_LSB +: TRACE_W];
  assign int_mask  = sr_word[MASK_LSB +: MASK_W];
  assign ccr_flags = sr_word[FLAG_W-1:0];
  assign sfc_code  = fc_q[0];
  assign dfc_code  = fc_q[1];
  assign a7_ptr    = active_sp;

endmodule

// File: rtl/priv_ctrl_regs_chk.sv
module priv_ctrl_regs_chk
  import priv_ctrl_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int FC_W   = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              acc_en,
  input logic              acc_wr,
  input logic [2:0]        acc_sel,
  input logic [1:0]        acc_size,
  input logic [DATA_W-1:0] acc_wdata,
  input logic [DATA_W-1:0] acc_rdata,
  input logic              priv_viol,
  input logic              size_err,
  input logic              super_mode,
  input logic [MASK_W-1:0] int_mask,
  input logic [DATA_W-1:0] a7_ptr
);

  logic rd_sr, rd_ccr, rd_fc;
  assign rd_sr  = acc_en && !acc_wr && (acc_sel == SEL_SR);
  assign rd_ccr = acc_en && !acc_wr && (acc_sel == SEL_CCR);
  assign rd_fc  = acc_en && !acc_wr && ((acc_sel == SEL_SFC) || (acc_sel == SEL_DFC));

  AST_SR_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rd_sr |-> (acc_rdata[DATA_W-1:SR_W] == '0 && acc_rdata[12:11] == 2'b00 && acc_rdata[7:5] == 3'b000)); // R2

  AST_CCR_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ccr |-> (acc_rdata[DATA_W-1:FLAG_W] == '0)); // R3

  AST_FC_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rd_fc |-> (acc_rdata[DATA_W-1:FC_W] == '0)); // R5

  AST_USER_SR_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && acc_wr && acc_sel == SEL_SR && !super_mode) |=> (priv_viol && !super_mode)); // R4

  AST_NO_SELF_ELEVATE: assert property (@(posedge clk) disable iff (!rst_n)
    !super_mode |=> !super_mode); // R4

  AST_USER_MASK_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !super_mode |=> $stable(int_mask)); // R4

  AST_SR_SIZE_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && super_mode && acc_sel == SEL_SR && acc_size != SZ_WORD) |=> size_err); // R8

  AST_ERR_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(priv_viol && size_err)); // R8

  AST_A7_LONG_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && acc_wr && acc_sel == SEL_A7 && acc_size == SZ_LONG) |=> (a7_ptr == $past(acc_wdata))); // R7

  AST_S_CLEAR_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && acc_wr && acc_sel == SEL_SR && acc_size == SZ_WORD && super_mode && !acc_wdata[S_BIT])
    |=> !super_mode); // R6

endmodule

bind priv_ctrl_regs priv_ctrl_regs_chk #(.DATA_W(DATA_W), .FC_W(FC_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .acc_en     (acc_en),
  .acc_wr     (acc_wr),
  .acc_sel    (acc_sel),
  .acc_size   (acc_size),
  .acc_wdata  (acc_wdata),
  .acc_rdata  (acc_rdata),
  .priv_viol  (priv_viol),
  .size_err   (size_err),
  .super_mode (super_mode),
  .int_mask   (int_mask),
  .a7_ptr     (a7_ptr)
);

// File: tb/priv_ctrl_regs_bench.sv
`timescale 1ns/1ps
module priv_ctrl_regs_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_en = 1'b0;
  logic        acc_wr = 1'b0;
  logic [2:0]  acc_sel = '0;
  logic [1:0]  acc_size = '0;
  logic [31:0] acc_wdata = '0;
  logic [31:0] acc_rdata;
  logic        priv_viol, size_err;
  logic        ccr_upd_en = 1'b0;
  logic [4:0]  ccr_upd_val = '0;
  logic [1:0]  trace_en;
  logic        super_mode;
  logic [2:0]  int_mask;
  logic [4:0]  ccr_flags;
  logic [2:0]  sfc_code, dfc_code;
  logic [31:0] a7_ptr;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic [15:0] m_sr;
  logic [31:0] m_usp, m_ssp;
  logic [2:0]  m_sfc, m_dfc;

  always #2.5 clk = ~clk;

  priv_ctrl_regs u_priv_ctrl_regs (
    .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .acc_wr(acc_wr),
    .acc_sel(acc_sel), .acc_size(acc_size), .acc_wdata(acc_wdata),
    .acc_rdata(acc_rdata), .priv_viol(priv_viol), .size_err(size_err),
    .ccr_upd_en(ccr_upd_en), .ccr_upd_val(ccr_upd_val),
    .trace_en(trace_en), .super_mode(super_mode), .int_mask(int_mask),
    .ccr_flags(ccr_flags), .sfc_code(sfc_code), .dfc_code(dfc_code),
    .a7_ptr(a7_ptr)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] pat(int i);
    case (i)
      0: return 32'hFFFF_FFFF;
      1: return 32'h0000_0000;
      2: return 32'hA5A5_5A5A;
      3: return 32'h5A5A_A5A5;
      4: return 32'h0000_8001;
      default: return 32'h8000_7FFE;
    endcase
  endfunction

  function automatic logic [31:0] sext16(logic [31:0] v);
    return {{16{v[15]}}, v[15:0]};
  endfunction

  task automatic check_outputs(string tag);
    chk({tag, " R10 trace"}, {30'd0, trace_en}, {30'd0, m_sr[15:14]});
    chk({tag, " R10 super"}, {31'd0, super_mode}, {31'd0, m_sr[13]});
    chk({tag, " R10 mask"}, {29'd0, int_mask}, {29'd0, m_sr[10:8]});
    chk({tag, " R10 flags"}, {27'd0, ccr_flags}, {27'd0, m_sr[4:0]});
    chk({tag, " R5 sfc"}, {29'd0, sfc_code}, {29'd0, m_sfc});
    chk({tag, " R5 dfc"}, {29'd0, dfc_code}, {29'd0, m_dfc});
    chk({tag, " R6 a7"}, a7_ptr, m_sr[13] ? m_ssp : m_usp);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    acc_en = 1'b0;
    ccr_upd_en = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    m_sr = 16'h2700; m_usp = '0; m_ssp = '0; m_sfc = '0; m_dfc = '0;
    #1;
    check_outputs("R1 reset");
    chk("R1 priv_viol", {31'd0, priv_viol}, 32'd0);
    chk("R1 size_err", {31'd0, size_err}, 32'd0);
  endtask

  task automatic acc(bit wr, logic [2:0] sel, logic [1:0] sz, logic [31:0] wd,
                     bit upd, logic [4:0] uv);
    bit s, need, good, pv, se, ok;
    logic [31:0] exp_rd;
    string tag;
    @(negedge clk);
    acc_en = 1'b1; acc_wr = wr; acc_sel = sel; acc_size = sz; acc_wdata = wd;
    ccr_upd_en = upd; ccr_upd_val = uv;
    #1;
    s = m_sr[13];
    need = (sel == 3'd0) || (sel == 3'd2) || (sel == 3'd3) || (sel == 3'd5);
    case (sel)
      3'd0, 3'd1: good = (sz == 2'd1);
      3'd2, 3'd3: good = (sz == 2'd2);
      3'd4, 3'd5: good = (sz == 2'd1) || (sz == 2'd2);
      default:    good = 1'b1;
    endcase
    pv = need && !s;
    se = !pv && !good;
    ok = !pv && good;
    case (sel)
      3'd0: tag = "R2 sr";
      3'd1: tag = "R3 ccr";
      3'd2, 3'd3: tag = "R5 fc";
      3'd4: tag = "R7 a7";
      3'd5: tag = "R7 usp";
      default: tag = "R11 unused";
    endcase
    exp_rd = '0;
    if (ok && !wr) begin
      case (sel)
        3'd0: exp_rd = {16'd0, m_sr};
        3'd1: exp_rd = {27'd0, m_sr[4:0]};
        3'd2: exp_rd = {29'd0, m_sfc};
        3'd3: exp_rd = {29'd0, m_dfc};
        3'd4: exp_rd = (sz == 2'd1) ? {16'd0, (s ? m_ssp[15:0] : m_usp[15:0])} : (s ? m_ssp : m_usp);
        3'd5: exp_rd = (sz == 2'd1) ? {16'd0, m_usp[15:0]} : m_usp;
        default: exp_rd = '0;
      endcase
    end
    chk({tag, " rdata"}, acc_rdata, exp_rd);
    if (ok && wr && sel == 3'd0) m_sr = wd[15:0] & 16'hE71F;
    else if (ok && wr && sel == 3'd1) m_sr[4:0] = wd[4:0];
    else if (upd) m_sr[4:0] = uv;
    if (ok && wr && sel == 3'd2) m_sfc = wd[2:0];
    if (ok && wr && sel == 3'd3) m_dfc = wd[2:0];
    if (ok && wr && sel == 3'd4) begin
      if (s) m_ssp = (sz == 2'd1) ? sext16(wd) : wd;
      else   m_usp = (sz == 2'd1) ? sext16(wd) : wd;
    end
    if (ok && wr && sel == 3'd5) m_usp = (sz == 2'd1) ? sext16(wd) : wd;
    @(posedge clk);
    #1;
    acc_en = 1'b0; ccr_upd_en = 1'b0;
    chk({tag, " R4 priv_viol"}, {31'd0, priv_viol}, {31'd0, pv});
    chk({tag, " R8 size_err"}, {31'd0, size_err}, {31'd0, se});
    check_outputs(tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    do_reset();

    // Supervisor sweep: every selector, size and direction across data patterns.
    for (int p = 0; p < 6; p++) begin
      for (int sel = 0; sel < 8; sel++) begin
        for (int sz = 0; sz < 4; sz++) begin
          for (int wr = 0; wr < 2; wr++) begin
            if (!m_sr[13]) do_reset();
            acc(wr[0], sel[2:0], sz[1:0], pat(p), 1'b0, 5'd0);
          end
        end
      end
    end

    // R6: distinct pointers, then drop to user mode.
    do_reset();
    acc(1'b1, 3'd4, 2'd2, 32'h1000_0000, 1'b0, 5'd0);
    acc(1'b1, 3'd5, 2'd1, 32'h0000_9004, 1'b0, 5'd0);
    chk("R7 usp sign extend", m_usp, 32'hFFFF_9004);
    acc(1'b1, 3'd2, 2'd2, 32'hFFFF_FFF5, 1'b0, 5'd0);
    acc(1'b1, 3'd0, 2'd1, 32'h0000_C51A, 1'b0, 5'd0);
    chk("R6 user alias", a7_ptr, 32'hFFFF_9004);
    chk("R6 super cleared", {31'd0, super_mode}, 32'd0);

    // User sweep: same crossing without privilege.
    for (int p = 0; p < 6; p++) begin
      for (int sel = 0; sel < 8; sel++) begin
        for (int sz = 0; sz < 4; sz++) begin
          for (int wr = 0; wr < 2; wr++) begin
            acc(wr[0], sel[2:0], sz[1:0], pat(p), 1'b0, 5'd0);
          end
        end
      end
    end

    // R9: direct flag update, alone and against a port write.
    acc(1'b0, 3'd6, 2'd0, 32'd0, 1'b1, 5'b10101);
    chk("R9 update alone", {27'd0, ccr_flags}, 32'h15);
    acc(1'b1, 3'd1, 2'd1, 32'hFFFF_FF0A, 1'b1, 5'b11111);
    chk("R9 port write wins", {27'd0, ccr_flags}, 32'h0A);
    acc(1'b1, 3'd0, 2'd1, 32'h0000_2700, 1'b1, 5'b00111);
    chk("R9 rejected sr write lets update through", {27'd0, ccr_flags}, 32'h07);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule